// File: doc/BRIEF.md
# Measurement Mode and Rate Controller

This block keeps the configuration registers of a three-axis field sensor and paces its measurement engine. A register bus from the serial slave writes a control word with operating mode, output rate, field range and oversampling fields. It also writes a second control word with the read-pointer wrap enable, the interrupt pin disable and a soft-reset command, and an 8-bit set/reset period value. The block decodes these fields and drives the range and oversampling selects of the measurement engine. In continuous mode it also issues one trigger pulse per output period.

The output period comes from a base tick input, which pulses once per 200 Hz period divided by `BASE_TICKS`. The 200, 100, 50 and 10 Hz rates take 1, 2, 4 and 20 times `BASE_TICKS` ticks. A soft reset clears every register, drops the block to standby and abandons any measurement in progress.

Top module: `meas_rate_ctrl`

## Requirements
- R1: After reset, address 0x09, 0x0A and 0x0B read 0x00, `measTrig` and `measAbort` are low, `rangeWide` is 0 and `osrLog2` is 9.
- R2: Control word 0x09 reads back as written. Its layout is bits 7:6 oversampling code, 5:4 range code, 3:2 rate code and 1:0 mode code. `rangeWide` is 1 only for range code 01 (±8 gauss, 00 is ±2 gauss). `osrLog2` is 9, 8, 7 or 6 for oversampling codes 00, 01, 10 and 11 (ratios 512, 256, 128, 64).
- R3: Address 0x0A keeps only bit 6 (pointer wrap, driven on `rollOverEn`) and bit 0 (interrupt disable, `intPinEn` is its inverse). Its other bits always read 0.
- R4: Address 0x0B holds any 8-bit value, is read back and appears on `srPeriod`. Address 0x0D always reads 0xFF, and writes to it have no effect.
- R5: In continuous mode (mode code 01), `measTrig` pulses for one cycle on every P-th tick. P is 20, 4, 2 or 1 times `BASE_TICKS` for rate codes 00, 01, 10 and 11 (10, 50, 100, 200 Hz).
- R6: In standby (mode code 00) and in the reserved mode codes, `measTrig` stays low and the rate counter is held.
- R7: Only clock cycles with `tickIn` high advance the rate counter, so the trigger spacing in clocks scales with the tick spacing.
- R8: Any write to 0x09 restarts the rate counter. The first trigger after the write comes on the P-th tick counted from the write.
- R9: A write to 0x0A with bit 7 set gives a one-cycle `measAbort` pulse in the cycle after the write. No trigger follows it.
- R10: The soft reset restores every register to its reset value and forces standby. Bit 7 of 0x0A reads back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one per write |
| regAddr | input | 8 | Register address for read and write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| tickIn | input | 1 | Base timing tick, one cycle per tick |
| measTrig | output | 1 | One-cycle measurement start pulse |
| measAbort | output | 1 | One-cycle abandon pulse on soft reset |
| rangeWide | output | 1 | 1 selects ±8 gauss, 0 selects ±2 gauss |
| osrLog2 | output | 4 | Log2 of the oversampling ratio |
| srPeriod | output | 8 | Set/reset period value |
| rollOverEn | output | 1 | Read-pointer wrap enable |
| intPinEn | output | 1 | Data-ready pin enable |

## Verification
Read data is combinational, so each read is checked within the same cycle, after the address settles. Register fields and decoded selects change at the write edge and are sampled at the falling edge that follows. `measAbort` is due in the cycle right after the soft-reset write edge. A trigger is due in the cycle after the clock edge that samples the P-th tick counted from the restarting write. The bench drives the tick at each falling edge and counts ticks itself. At every following falling edge it compares `measTrig` with its own tick count, so an early, late or extra pulse is caught in the exact cycle it occurs.

// File: rtl/measctl_pkg.sv
package measctl_pkg;
  localparam logic [7:0] ADDR_CTRL1 = 8'h09;
  localparam logic [7:0] ADDR_CTRL2 = 8'h0A;
  localparam logic [7:0] ADDR_SRPER = 8'h0B;
  localparam logic [7:0] ADDR_IDENT = 8'h0D;
  localparam logic [7:0] IDENT_VAL  = 8'hFF;

  typedef enum logic [1:0] {
    MODE_STBY = 2'b00,
    MODE_CONT = 2'b01,
    MODE_RSV2 = 2'b10,
    MODE_RSV3 = 2'b11
  } opMode_t;

  typedef struct packed {
    logic restart;
    logic softReset;
  } ctlStrobe_t;
endpackage

// File: rtl/meas_ctrl_regs.sv
module meas_ctrl_regs
  import measctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output ctlStrobe_t strobe,
  output logic       isCont,
  output logic [1:0] odrSel,
  output logic       rangeWide,
  output logic [3:0] osrLog2,
  output logic [7:0] srPeriod,
  output logic       rollOverEn,
  output logic       intPinEn
);
  logic [7:0] ctrlWord;
  logic       wrapBit;
  logic       intOff;
  logic [7:0] srReg;

  always_comb begin
    strobe.softReset = regWrEn && (regAddr == ADDR_CTRL2) && regWrData[7];
    strobe.restart   = regWrEn && (regAddr == ADDR_CTRL1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord <= '0;
      wrapBit  <= 1'b0;
      intOff   <= 1'b0;
      srReg    <= '0;
    end else if (strobe.softReset) begin
      ctrlWord <= '0;
      wrapBit  <= 1'b0;
      intOff   <= 1'b0;
      srReg    <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_CTRL1: ctrlWord <= regWrData;
        ADDR_CTRL2: begin
          wrapBit <= regWrData[6];
          intOff  <= regWrData[0];
        end
        ADDR_SRPER: srReg <= regWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL1: regRdData = ctrlWord;
      ADDR_CTRL2: regRdData = {1'b0, wrapBit, 5'b0, intOff};
      ADDR_SRPER: regRdData = srReg;
      ADDR_IDENT: regRdData = IDENT_VAL;
      default:    regRdData = 8'h00;
    endcase
  end

  assign isCont     = (opMode_t'(ctrlWord[1:0]) == MODE_CONT);
  assign odrSel     = ctrlWord[3:2];
  assign rangeWide  = (ctrlWord[5:4] == 2'b01);
  assign osrLog2    = 4'd9 - {2'b00, ctrlWord[7:6]};
  assign srPeriod   = srReg;
  assign rollOverEn = wrapBit;
  assign intPinEn   = ~intOff;

  // R10: soft reset leaves standby and cleared registers behind
  p_softrst_clears_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.softReset) |-> (ctrlWord == 8'h00 && !wrapBit && !intOff && srReg == 8'h00));

  // R4: identity register never changes
  p_ident_fixed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_IDENT) |-> (regRdData == IDENT_VAL));

  // R3: unused bits of control word 2 read as zero
  p_ctrl2_unused_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CTRL2) |-> (regRdData[7] == 1'b0 && regRdData[5:1] == 5'b0));
endmodule

// File: rtl/meas_rate_timer.sv
module meas_rate_timer
  import measctl_pkg::*;
#(
  parameter int BASE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic       isCont,
  input  logic [1:0] odrSel,
  input  logic       tickIn,
  output logic       measTrig,
  output logic       measAbort
);
  localparam int MAX_PERIOD = BASE_TICKS * 20;
  localparam int CNT_W = (MAX_PERIOD > 2) ? $clog2(MAX_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST_10HZ  = CNT_W'(BASE_TICKS * 20 - 1);
  localparam logic [CNT_W-1:0] LAST_50HZ  = CNT_W'(BASE_TICKS * 4 - 1);
  localparam logic [CNT_W-1:0] LAST_100HZ = CNT_W'(BASE_TICKS * 2 - 1);
  localparam logic [CNT_W-1:0] LAST_200HZ = CNT_W'(BASE_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] lastCnt;

  always_comb begin
    case (odrSel)
      2'b00:   lastCnt = LAST_10HZ;
      2'b01:   lastCnt = LAST_50HZ;
      2'b10:   lastCnt = LAST_100HZ;
      default: lastCnt = LAST_200HZ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt   <= '0;
      measTrig  <= 1'b0;
      measAbort <= 1'b0;
    end else begin
      measAbort <= strobe.softReset;
      if (strobe.softReset || strobe.restart || !isCont) begin
        tickCnt  <= '0;
        measTrig <= 1'b0;
      end else if (tickIn) begin
        if (tickCnt == lastCnt) begin
          tickCnt  <= '0;
          measTrig <= 1'b1;
        end else begin
          tickCnt  <= tickCnt + 1'b1;
          measTrig <= 1'b0;
        end
      end else begin
        measTrig <= 1'b0;
      end
    end
  end

  // R6: triggers only follow a cycle spent in continuous mode
  p_trig_only_cont_r6: assert property (@(posedge clk) disable iff (!rstN)
    measTrig |-> $past(isCont));

  // R7: every trigger is caused by a tick
  p_trig_needs_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    measTrig |-> $past(tickIn));

  // R8: a restart never produces a trigger in the next cycle
  p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.restart) |-> !measTrig);

  // R9: abandon pulse is single-cycle and never joined by a trigger
  p_abort_alone_r9: assert property (@(posedge clk) disable iff (!rstN)
    measAbort |-> (!measTrig && $past(strobe.softReset)));
endmodule

// File: rtl/meas_rate_ctrl.sv
module meas_rate_ctrl
  import measctl_pkg::*;
#(
  parameter int BASE_TICKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       tickIn,
  output logic       measTrig,
  output logic       measAbort,
  output logic       rangeWide,
  output logic [3:0] osrLog2,
  output logic [7:0] srPeriod,
  output logic       rollOverEn,
  output logic       intPinEn
);
  ctlStrobe_t strobe;
  logic       isCont;
  logic [1:0] odrSel;

  meas_ctrl_regs u_regs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .isCont(isCont), .odrSel(odrSel), .rangeWide(rangeWide),
    .osrLog2(osrLog2), .srPeriod(srPeriod), .rollOverEn(rollOverEn),
    .intPinEn(intPinEn)
  );

  meas_rate_timer #(.BASE_TICKS(BASE_TICKS)) u_timer (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isCont(isCont),
    .odrSel(odrSel), .tickIn(tickIn), .measTrig(measTrig),
    .measAbort(measAbort)
  );
endmodule

// File: tb/sim_meas_rate_ctrl.sv
`timescale 1ns/1ps
module sim_meas_rate_ctrl;
  localparam int BT = 4;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic tickIn = 1'b0;
  logic [7:0] regRdData;
  logic measTrig, measAbort, rangeWide, rollOverEn, intPinEn;
  logic [3:0] osrLog2;
  logic [7:0] srPeriod;
  int nCmp = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  meas_rate_ctrl #(.BASE_TICKS(BT)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .tickIn(tickIn),
    .measTrig(measTrig), .measAbort(measAbort), .rangeWide(rangeWide),
    .osrLog2(osrLog2), .srPeriod(srPeriod), .rollOverEn(rollOverEn),
    .intPinEn(intPinEn)
  );

  task automatic chk(string tag, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(logic [7:0] a, logic [7:0] exp, string tag);
    regAddr = a;
    #0.5;
    chk(tag, regRdData, exp);
  endtask

  // period 0 means no trigger may appear; alt ticks every other cycle
  task automatic runTrig(int period, int cycles, bit alt, string tag);
    int ticks = 0;
    int bad = 0;
    for (int k = 1; k <= cycles; k++) begin
      bit t = alt ? bit'(k % 2) : 1'b1;
      bit exp;
      tickIn = t;
      @(negedge clk);
      if (t) ticks++;
      exp = (period != 0) && t && (ticks % period == 0);
      if (measTrig !== exp) begin
        bad++;
        $display("FAIL %s cycle %0d actual=%0b expected=%0b", tag, k, measTrig, exp);
      end
    end
    tickIn = 1'b0;
    nCmp++;
    if (bad != 0) nBad++;
  endtask

  task automatic t_reset();
    rdChk(8'h09, 8'h00, "R1 ctrl1");
    rdChk(8'h0A, 8'h00, "R1 ctrl2");
    rdChk(8'h0B, 8'h00, "R1 srper");
    chk("R1 trig", measTrig, 0);
    chk("R1 abort", measAbort, 0);
    chk("R1 range", rangeWide, 0);
    chk("R1 osr", osrLog2, 9);
  endtask

  task automatic t_fields();
    wr(8'h09, 8'h1C);
    rdChk(8'h09, 8'h1C, "R2 readback");
    chk("R2 range wide", rangeWide, 1);
    chk("R2 osr512", osrLog2, 9);
    wr(8'h09, 8'hE0);
    chk("R2 range reserved", rangeWide, 0);
    chk("R2 osr64", osrLog2, 6);
    wr(8'h09, 8'h40);
    chk("R2 osr256", osrLog2, 8);
    chk("R2 range narrow", rangeWide, 0);
  endtask

  task automatic t_ctrl2();
    wr(8'h0A, 8'h7F);
    rdChk(8'h0A, 8'h41, "R3 masked");
    chk("R3 wrap", rollOverEn, 1);
    chk("R3 intpin", intPinEn, 0);
    wr(8'h0A, 8'h00);
    chk("R3 intpin on", intPinEn, 1);
  endtask

  task automatic t_misc();
    wr(8'h0B, 8'h01);
    rdChk(8'h0B, 8'h01, "R4 srper");
    chk("R4 srper port", srPeriod, 1);
    wr(8'h0D, 8'h00);
    rdChk(8'h0D, 8'hFF, "R4 ident");
  endtask

  task automatic t_rates();
    wr(8'h09, 8'h0D); runTrig(BT, 3 * BT + 2, 1'b0, "R5 200Hz");
    wr(8'h09, 8'h09); runTrig(2 * BT, 3 * 2 * BT, 1'b0, "R5 100Hz");
    wr(8'h09, 8'h05); runTrig(4 * BT, 2 * 4 * BT + 3, 1'b0, "R5 50Hz");
    wr(8'h09, 8'h01); runTrig(20 * BT, 2 * 20 * BT + 1, 1'b0, "R5 10Hz");
  endtask

  task automatic t_standby();
    wr(8'h09, 8'h0C); runTrig(0, 60, 1'b0, "R6 standby");
    wr(8'h09, 8'h0E); runTrig(0, 60, 1'b0, "R6 reserved");
  endtask

  task automatic t_ticks();
    wr(8'h09, 8'h09); runTrig(2 * BT, 8 * BT, 1'b1, "R7 sparse ticks");
  endtask

  task automatic t_restart();
    wr(8'h09, 8'h09);
    runTrig(2 * BT, 2 * BT - 2, 1'b0, "R8 partial");
    wr(8'h09, 8'h09);
    runTrig(2 * BT, 2 * 2 * BT, 1'b0, "R8 after restart");
  endtask

  task automatic t_softrst();
    wr(8'h0B, 8'h5A);
    wr(8'h0A, 8'h41);
    wr(8'h09, 8'h1D);
    runTrig(BT, BT + 1, 1'b0, "R9 pre");
    wr(8'h0A, 8'h80);
    chk("R9 abort pulse", measAbort, 1);
    @(negedge clk);
    chk("R9 abort single", measAbort, 0);
    rdChk(8'h0A, 8'h00, "R10 ctrl2 selfclear");
    rdChk(8'h09, 8'h00, "R10 ctrl1 default");
    rdChk(8'h0B, 8'h00, "R10 srper default");
    chk("R10 range", rangeWide, 0);
    runTrig(0, 40, 1'b0, "R9 no trig after");
  endtask

  initial begin
    #(200000 * 5);
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_ctrl2();
    t_misc();
    t_rates();
    t_standby();
    t_ticks();
    t_restart();
    t_softrst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule